// File: doc/BRIEF.md
# Sign-Magnitude Sample Quantizer

This block turns a signed fixed-point sample into a sign flag and an unsigned magnitude code. The sign flag is 0 for a negative sample and 1 otherwise. The magnitude is the sample's absolute value measured against a programmable reference. The reference is scaled so that a sample equal in size to the reference maps to the largest code, 2^(MAG_W-1)-1. Fractions are truncated toward zero, and anything at or beyond the reference saturates.

A sampling strobe decides when a new result is captured. The result appears on the outputs one clock after the strobe and is held until the next strobe. Sample and reference use the same two's-complement format, DATA_W bits wide. Only a strictly positive reference is meaningful; any other reference forces the largest code. The arithmetic is one multiply, a compare against the scaled reference, and a short restoring divide that only has to produce MAG_W-1 quotient bits.

Top module: `sm_quantizer`

## Requirements
- R1: `sgn_out` is 0 after capturing a negative sample and 1 after capturing a zero or positive sample.
- R2: For a positive `vref` and a sample with |x| < `vref`, `mag_out` equals floor(|x| * (2^(MAG_W-1)-1) / `vref`). With MAG_W=8 and `vref`=16384, x=8192 gives 63 and x=16383 gives 126.
- R3: `mag_out` never exceeds 2^(MAG_W-1)-1. Any sample with |x| >= `vref` gives exactly that code; this includes samples 10% beyond the reference in either direction and the most negative input value.
- R4: When `sample_en` is low, `sgn_out` and `mag_out` keep their values whatever `sample_in` and `vref` do.
- R5: A high `rst` at a clock edge sets `sgn_out` to 1 and `mag_out` to 0. This takes priority over `sample_en`.
- R6: A sample presented with `sample_en` high at an edge appears on the outputs right after that edge (one cycle of latency). The outputs do not change before that edge.
- R7: If `vref` is zero or negative, a captured sample gives the largest magnitude code, and the sign still follows R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Capture strobe for the current sample |
| sample_in | input | DATA_W | Signed two's-complement sample |
| vref | input | DATA_W | Signed full-scale reference, same format as the sample |
| sgn_out | output | 1 | Sign flag: 0 negative, 1 zero or positive |
| mag_out | output | MAG_W | Truncated, saturated magnitude code |

## Verification
The properties assume that `sample_in` and `vref` are at known levels whenever `sample_en` is high. They also assume that a reset may arrive at any cycle, so every property is cancelled while `rst` is high. The floor property compares the registered code against the product and reference values one cycle earlier. It therefore relies on the inputs being held only through the strobe cycle.

The stimulus changes inputs only at falling edges and samples outputs at the next falling edge. Each sample lies in the full signed range, including the most negative value. The table holds references at a small value, at half range and at full range, plus zero and negative references for R7.

// File: rtl/qz_pkg.sv
package qz_pkg;

  // Sign flag encoding seen at the output
  localparam logic SGN_NEG = 1'b0;
  localparam logic SGN_POS = 1'b1;

  // Largest magnitude code for a code of n bits: 2^(n-1)-1
  function automatic int full_code(input int n);
    return (1 << (n - 1)) - 1;
  endfunction

endpackage

// File: rtl/qz_front.sv
module qz_front #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] vref_i,
  output logic                     neg_o,
  output logic        [DATA_W-1:0] abs_o,
  output logic        [DATA_W-1:0] vref_mag_o,
  output logic                     vref_ok_o
);

  // Absolute value as unsigned; the most negative input maps to 2^(DATA_W-1)
  function automatic logic [DATA_W-1:0] magnitude_of(input logic signed [DATA_W-1:0] v);
    logic [DATA_W-1:0] raw;
    raw = v;
    return v[DATA_W-1] ? (~raw + DATA_W'(1)) : raw;
  endfunction

  assign neg_o      = sample_i[DATA_W-1];
  assign abs_o      = magnitude_of(sample_i);
  assign vref_mag_o = vref_i;
  assign vref_ok_o  = !vref_i[DATA_W-1] && (vref_i != '0);

endmodule

// File: rtl/qz_scale.sv
module qz_scale
  import qz_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAG_W  = 8
) (
  input  logic [DATA_W-1:0]        abs_i,
  input  logic [DATA_W-1:0]        vref_i,
  input  logic                     vref_ok_i,
  output logic [MAG_W-1:0]         code_o,
  output logic                     sat_o,
  output logic [DATA_W+MAG_W-1:0]  prod_o
);

  localparam int PW = DATA_W + MAG_W;
  localparam int QW = MAG_W - 1;
  localparam logic [PW-1:0]    FULL_P = PW'(full_code(MAG_W));
  localparam logic [MAG_W-1:0] FULL_C = MAG_W'(full_code(MAG_W));

  function automatic logic [PW-1:0] widen(input logic [DATA_W-1:0] v);
    return PW'(v);
  endfunction

  logic [PW-1:0] limit_w;
  logic [PW-1:0] rem_w [1:QW];
  logic [QW-1:0] quot_w;

  // Scaled sample and scaled reference share one constant factor
  assign prod_o  = widen(abs_i) * FULL_P;
  assign limit_w = widen(vref_i) * FULL_P;
  assign sat_o   = !vref_ok_i || (prod_o >= limit_w);

  // Below saturation the quotient is under 2^QW, so QW restoring steps suffice
  for (genvar g = 0; g < QW; g++) begin : g_div
    logic [PW-1:0] in_w;
    logic [PW-1:0] trial_w;
    if (g == QW - 1) begin : g_first
      assign in_w = prod_o;
    end else begin : g_next
      assign in_w = rem_w[g+1];
    end
    assign trial_w   = widen(vref_i) << g;
    assign quot_w[g] = in_w >= trial_w;
    if (g > 0) begin : g_rem
      assign rem_w[g] = quot_w[g] ? (in_w - trial_w) : in_w;
    end
  end

  assign code_o = sat_o ? FULL_C : {1'b0, quot_w};

endmodule

// File: rtl/qz_hold.sv
module qz_hold
  import qz_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             sgn_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             sgn_o,
  output logic [MAG_W-1:0] mag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sgn_o <= SGN_POS;
      mag_o <= '0;
    end else if (load_i) begin
      sgn_o <= sgn_i;
      mag_o <= mag_i;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(sgn_o) && $stable(mag_o)));

endmodule

// File: rtl/sm_quantizer.sv
module sm_quantizer
  import qz_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_en,
  input  logic signed [DATA_W-1:0] sample_in,
  input  logic signed [DATA_W-1:0] vref,
  output logic                     sgn_out,
  output logic        [MAG_W-1:0]  mag_out
);

  localparam int PW = DATA_W + MAG_W;
  localparam logic [MAG_W-1:0] FULL_C = MAG_W'(full_code(MAG_W));

  logic              neg_w;
  logic [DATA_W-1:0] abs_w;
  logic [DATA_W-1:0] vref_mag_w;
  logic              vref_ok_w;
  logic [MAG_W-1:0]  code_w;
  logic              sat_w;
  logic [PW-1:0]     prod_w;
  logic              sgn_next_w;

  qz_front #(.DATA_W(DATA_W)) front_i (
    .sample_i   (sample_in),
    .vref_i     (vref),
    .neg_o      (neg_w),
    .abs_o      (abs_w),
    .vref_mag_o (vref_mag_w),
    .vref_ok_o  (vref_ok_w)
  );

  qz_scale #(.DATA_W(DATA_W), .MAG_W(MAG_W)) scale_i (
    .abs_i     (abs_w),
    .vref_i    (vref_mag_w),
    .vref_ok_i (vref_ok_w),
    .code_o    (code_w),
    .sat_o     (sat_w),
    .prod_o    (prod_w)
  );

  assign sgn_next_w = neg_w ? SGN_NEG : SGN_POS;

  qz_hold #(.MAG_W(MAG_W)) hold_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (sample_en),
    .sgn_i  (sgn_next_w),
    .mag_i  (code_w),
    .sgn_o  (sgn_out),
    .mag_o  (mag_out)
  );

  // Sign convention, seen one cycle after the strobe (R1, R6)
  assert_sign_neg_R1: assert property (@(posedge clk) disable iff (rst)
    (sample_en && sample_in[DATA_W-1]) |=> (sgn_out == SGN_NEG));
  assert_sign_pos_R1: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !sample_in[DATA_W-1]) |=> (sgn_out == SGN_POS));

  // Truncation: code*vref <= product < (code+1)*vref
  assert_mag_floor_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !sat_w) |=>
      ((PW'(mag_out) * $past(vref_mag_w) <= $past(prod_w)) &&
       ($past(prod_w) < (PW'(mag_out) + PW'(1)) * $past(vref_mag_w))));

  assert_mag_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (mag_out <= FULL_C));
  assert_sat_max_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_en && sat_w) |=> (mag_out == FULL_C));

  assert_badref_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !vref_ok_w) |=> (mag_out == FULL_C));

endmodule

// File: tb/sm_quantizer_tb_top.sv
module sm_quantizer_tb_top;

  localparam int DW = 16;
  localparam int MW = 8;
  localparam int NV = 16;

  // Stimulus / expected vectors for MAG_W=8 (full code 127)
  localparam int VX   [NV] = '{0, 16384, -16384, 8192, -8192, 18022, -18022, -32768,
                               1, -1, 16383, 129, 130, 12345, -500, 32767};
  localparam int VREF [NV] = '{16384, 16384, 16384, 16384, 16384, 16384, 16384, 16384,
                               16384, 16384, 16384, 16384, 16384, 32767, 1000, 32767};
  localparam int VSGN [NV] = '{1, 1, 0, 1, 0, 1, 0, 0, 1, 0, 1, 1, 1, 1, 0, 1};
  localparam int VMAG [NV] = '{0, 127, 127, 63, 63, 127, 127, 127,
                               0, 0, 126, 0, 1, 47, 63, 127};
  localparam bit VSAT [NV] = '{0, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 sample_en = 1'b0;
  logic signed [DW-1:0] sample_in = '0;
  logic signed [DW-1:0] vref = '0;
  logic                 sgn_out;
  logic        [MW-1:0] mag_out;

  int n_checks = 0;
  int n_err    = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sm_quantizer #(.DATA_W(DW), .MAG_W(MW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .sample_in (sample_in),
    .vref      (vref),
    .sgn_out   (sgn_out),
    .mag_out   (mag_out)
  );

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  // Present one sample with the strobe, then return one falling edge later
  task automatic capture(input int x, input int r);
    @(negedge clk);
    sample_in = DW'(x);
    vref      = DW'(r);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check_val("R5 reset sgn", 32'(sgn_out), 32'd1);
    check_val("R5 reset mag", 32'(mag_out), 32'd0);
    rst = 1'b0;

    // Table walk: R1 sign, R2 truncation, R3 saturation
    for (int i = 0; i < NV; i++) begin
      capture(VX[i], VREF[i]);
      check_val("R1 sign", 32'(sgn_out), 32'(VSGN[i]));
      if (VSAT[i]) check_val("R3 saturated mag", 32'(mag_out), 32'(VMAG[i]));
      else         check_val("R2 truncated mag", 32'(mag_out), 32'(VMAG[i]));
    end

    // R7: zero and negative reference
    capture(5, 0);
    check_val("R7 zero ref mag", 32'(mag_out), 32'd127);
    check_val("R7 zero ref sgn", 32'(sgn_out), 32'd1);
    capture(-3, -100);
    check_val("R7 negative ref mag", 32'(mag_out), 32'd127);
    check_val("R7 negative ref sgn", 32'(sgn_out), 32'd0);

    // R4: inputs move without the strobe
    capture(-8192, 16384);
    @(negedge clk);
    sample_in = DW'(16384);
    vref      = DW'(1000);
    repeat (3) @(negedge clk);
    check_val("R4 held sgn", 32'(sgn_out), 32'd0);
    check_val("R4 held mag", 32'(mag_out), 32'd63);

    // R6: no change before the capturing edge, new value right after it
    sample_in = DW'(16384);
    vref      = DW'(16384);
    sample_en = 1'b1;
    #1;
    check_val("R6 before edge mag", 32'(mag_out), 32'd63);
    @(negedge clk);
    sample_en = 1'b0;
    check_val("R6 after edge mag", 32'(mag_out), 32'd127);
    check_val("R6 after edge sgn", 32'(sgn_out), 32'd1);

    // R5: reset wins over the strobe
    sample_in = DW'(-16384);
    sample_en = 1'b1;
    rst       = 1'b1;
    @(negedge clk);
    rst       = 1'b0;
    sample_en = 1'b0;
    check_val("R5 reset over strobe sgn", 32'(sgn_out), 32'd1);
    check_val("R5 reset over strobe mag", 32'(mag_out), 32'd0);

    done = 1'b1;
    finish_run();
  end

endmodule